// File: doc/BRIEF.md
# Double-Precision to Unsigned 64-bit Truncating Converter

This unit turns one IEEE-754 binary64 operand into an unsigned 64-bit integer. The fractional part is always dropped, so the result moves toward zero. The operand and a valid strobe enter on one clock edge. The converted value, its write enable and the exception and status bits appear on the following edge, together with a one-cycle result strobe.

Out-of-range operands saturate to one of the two unsigned bounds and raise the invalid-conversion flag. NaN operands give zero. A signalling NaN also raises its own flag. When the caller enables the invalid exception and an invalid condition occurs, the unit withholds the write and clears both rounding status bits. The 128-bit destination carries the integer in one half and zeros in the other.

Top module: `fp64_to_u64_trunc`

## Requirements
- R1: A conversion strobed by `in_valid` at one rising edge presents its results, with `out_valid` high, after the next rising edge. `out_valid` is low in every other cycle, and all outputs are zero after reset.
- R2: Finite operands from 0 up to just below 2^64 produce the integer part of the operand, with the fraction discarded. Values of 2^52 or more are exact.
- R3: Zero of either sign gives 0 with no flags. Denormals, and any operand whose magnitude is below 1.0 (negative ones included), give 0 with `out_inexact` set and `out_inv_cvt` clear.
- R4: A truncated value above 2^64-1, +infinity included, gives 0xFFFF_FFFF_FFFF_FFFF and sets `out_inv_cvt`.
- R5: A truncated value below zero (operands of -1.0 or less, -infinity included) gives 0 and sets `out_inv_cvt`.
- R6: A NaN (exponent all ones, fraction nonzero) gives 0 and sets `out_inv_cvt`. A signalling NaN (fraction bit 51 clear) also sets `out_inv_snan`.
- R7: `out_inexact` is set exactly when nonzero fraction bits were discarded from a finite, in-range operand. It is never set together with `out_inv_cvt`.
- R8: The integer is placed on `out_data[63:0]`, and `out_data[127:64]` is always zero.
- R9: When `inv_en` is high and either invalid flag is raised, `out_we` is low and both `out_frac_rnd` and `out_frac_inx` are zero. Otherwise `out_we` equals `out_valid`.
- R10: On a conversion that is written, `out_frac_inx` equals `out_inexact` and `out_frac_rnd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | binary64 operand |
| inv_en | input | 1 | Invalid-exception enable |
| out_valid | output | 1 | Result strobe, one cycle |
| out_we | output | 1 | Destination write enable |
| out_data | output | 128 | Destination value |
| out_inv_snan | output | 1 | Signalling-NaN invalid flag |
| out_inv_cvt | output | 1 | Invalid-conversion flag |
| out_inexact | output | 1 | Inexact flag |
| out_frac_rnd | output | 1 | Fraction-rounded status bit |
| out_frac_inx | output | 1 | Fraction-inexact status bit |

## Verification
The assertions assume that `in_valid`, `inv_en` and `in_op` are two-state, and that they change only away from the rising edge. The bench drives every input on the falling edge and keeps it steady for a full cycle. The checker relates only the result ports to each other and to the strobe from one cycle earlier, so it holds for any operand bit pattern. The bench therefore sweeps all the operand classes (zeros, denormals, fractions, exact large values, both infinities, both NaN kinds) with the exception enable both low and high.

// File: rtl/fp64_to_u64_trunc.sv
module fp64_to_u64_trunc #(
  parameter int unsigned EXP_W = 11,
  parameter int unsigned MAN_W = 52,
  parameter int unsigned INT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [63:0]        in_op,
  input  logic               inv_en,
  output logic               out_valid,
  output logic               out_we,
  output logic [127:0]       out_data,
  output logic               out_inv_snan,
  output logic               out_inv_cvt,
  output logic               out_inexact,
  output logic               out_frac_rnd,
  output logic               out_frac_inx
);
  localparam int unsigned BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int unsigned SIG_W = MAN_W + 1;
  localparam int unsigned WIDE  = 2 * INT_W;
  localparam int unsigned E_ONE = BIAS;
  localparam int unsigned E_OVF = BIAS + INT_W;
  localparam int unsigned R_OFS = BIAS + MAN_W + INT_W;

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] fr;
  logic             ex_max, ex_zero, fr_zero;
  logic [SIG_W-1:0] sig;
  logic [WIDE-1:0]  wide, shifted, lostmask;
  logic [7:0]       rsh;
  logic [INT_W-1:0] c_val;
  logic             c_snan, c_cvi, c_inx;

  assign sgn     = in_op[EXP_W+MAN_W];
  assign ex      = in_op[EXP_W+MAN_W-1:MAN_W];
  assign fr      = in_op[MAN_W-1:0];
  assign ex_max  = &ex;
  assign ex_zero = ~|ex;
  assign fr_zero = ~|fr;
  assign sig     = {~ex_zero, fr};
  assign wide    = {{(WIDE-INT_W-SIG_W){1'b0}}, sig, {INT_W{1'b0}}};
  assign rsh     = 8'(R_OFS - 32'(ex));
  assign shifted = wide >> rsh;
  assign lostmask = (WIDE'(1) << rsh) - WIDE'(1);

  always_comb begin
    c_val  = '0;
    c_snan = 1'b0;
    c_cvi  = 1'b0;
    c_inx  = 1'b0;
    if (ex_max) begin
      c_cvi = 1'b1;
      if (!fr_zero) c_snan = ~fr[MAN_W-1];
      else if (!sgn) c_val = '1;
    end else if (32'(ex) < E_ONE) begin
      c_inx = ~(ex_zero & fr_zero);
    end else if (sgn) begin
      c_cvi = 1'b1;
    end else if (32'(ex) >= E_OVF) begin
      c_cvi = 1'b1;
      c_val = '1;
    end else begin
      c_val = shifted[INT_W-1:0];
      c_inx = |(wide & lostmask);
    end
  end

  logic vex;
  assign vex = inv_en & (c_snan | c_cvi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_we       <= 1'b0;
      out_data     <= '0;
      out_inv_snan <= 1'b0;
      out_inv_cvt  <= 1'b0;
      out_inexact  <= 1'b0;
      out_frac_rnd <= 1'b0;
      out_frac_inx <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_we    <= in_valid & ~vex;
      if (in_valid) begin
        out_data     <= {64'b0, 64'(c_val)};
        out_inv_snan <= c_snan;
        out_inv_cvt  <= c_cvi;
        out_inexact  <= c_inx;
        out_frac_rnd <= 1'b0;
        out_frac_inx <= vex ? 1'b0 : c_inx;
      end
    end
  end
endmodule

// File: rtl/fp64_to_u64_trunc_chk.sv
module fp64_to_u64_trunc_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         inv_en,
  input logic         out_valid,
  input logic         out_we,
  input logic [127:0] out_data,
  input logic         out_inv_snan,
  input logic         out_inv_cvt,
  input logic         out_inexact,
  input logic         out_frac_rnd,
  input logic         out_frac_inx
);
  a_r1_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_we);
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[127:64] == 64'b0);
  a_r6_snan_implies_cvt: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_inv_snan |-> out_inv_cvt);
  a_r6_nan_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_inv_snan |-> out_data[63:0] == 64'b0);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_inv_cvt |-> !out_inexact);
  a_r9_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_we |-> !out_frac_rnd && !out_frac_inx && (out_inv_cvt || out_inv_snan));
  a_r9_enable_rule: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !inv_en |=> out_we);
  a_r10_frac_inx: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_we |-> out_frac_inx == out_inexact && !out_frac_rnd);
endmodule

bind fp64_to_u64_trunc fp64_to_u64_trunc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inv_en(inv_en),
  .out_valid(out_valid), .out_we(out_we), .out_data(out_data),
  .out_inv_snan(out_inv_snan), .out_inv_cvt(out_inv_cvt),
  .out_inexact(out_inexact), .out_frac_rnd(out_frac_rnd),
  .out_frac_inx(out_frac_inx)
);

// File: tb/sim_fp64_to_u64_trunc.sv
module sim_fp64_to_u64_trunc;
  logic clk = 0, rst_n = 0, in_valid = 0, inv_en = 0;
  logic [63:0] in_op = '0;
  logic out_valid, out_we, out_inv_snan, out_inv_cvt, out_inexact, out_frac_rnd, out_frac_inx;
  logic [127:0] out_data;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  fp64_to_u64_trunc u0 (.*);

  localparam int N = 19;
  // operand, expected integer, expected {snan,cvi,inexact}
  localparam logic [63:0] OPS [N] = '{
    64'h3FF0000000000000, 64'h3FF8000000000000, 64'h4006000000000000,
    64'hBFE0000000000000, 64'h8000000000000000, 64'h0000000000000000,
    64'h0000000000000001, 64'hBFF0000000000000, 64'h7FF0000000000000,
    64'hFFF0000000000000, 64'h7FF8000000000000, 64'h7FF0000000000001,
    64'h43E0000000000000, 64'h43EFFFFFFFFFFFFF, 64'h43F0000000000000,
    64'h4330000000000000, 64'h432FFFFFFFFFFFFF, 64'h3FEFFFFFFFFFFFFF,
    64'h4059000000000000};
  localparam logic [63:0] EXPV [N] = '{
    64'd1, 64'd1, 64'd2,
    64'd0, 64'd0, 64'd0,
    64'd0, 64'd0, 64'hFFFFFFFFFFFFFFFF,
    64'd0, 64'd0, 64'd0,
    64'h8000000000000000, 64'hFFFFFFFFFFFFF800, 64'hFFFFFFFFFFFFFFFF,
    64'h0010000000000000, 64'h000FFFFFFFFFFFFF, 64'd0,
    64'd100};
  localparam logic [2:0] EXPF [N] = '{
    3'b000, 3'b001, 3'b001,
    3'b001, 3'b000, 3'b000,
    3'b001, 3'b010, 3'b010,
    3'b010, 3'b010, 3'b110,
    3'b000, 3'b000, 3'b010,
    3'b000, 3'b001, 3'b001,
    3'b000};
  localparam string TAG [N] = '{
    "R2", "R7", "R7", "R3", "R3", "R3", "R3", "R5", "R4", "R5",
    "R6", "R6", "R2", "R2", "R4", "R2", "R7", "R3", "R2"};

  task automatic chk(input string r, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic conv(input logic [63:0] op, input logic en);
    @(negedge clk);
    in_op = op; inv_en = en; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {out_valid, out_we, out_data, out_inv_snan, out_inv_cvt, out_inexact, out_frac_rnd, out_frac_inx}, '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle", {out_valid, out_we}, 0);
    for (int i = 0; i < N; i++) begin
      conv(OPS[i], 1'b0);
      chk("R1 strobe", {out_valid, out_we}, 2'b11);
      chk({TAG[i], " value"}, out_data, {64'b0, EXPV[i]});
      chk({TAG[i], " flags"}, {out_inv_snan, out_inv_cvt, out_inexact}, EXPF[i]);
      chk("R10 status", {out_frac_rnd, out_frac_inx}, {1'b0, EXPF[i][0]});
      chk("R8 upper", out_data[127:64], 0);
    end
    @(negedge clk);
    chk("R1 single pulse", out_valid, 0);
    conv(64'h7FF0000000000001, 1'b1);
    chk("R9 snan suppressed", {out_valid, out_we, out_inv_snan, out_inv_cvt, out_frac_rnd, out_frac_inx}, 6'b101100);
    conv(64'hFFF0000000000000, 1'b1);
    chk("R9 -inf suppressed", {out_we, out_inv_cvt, out_frac_inx}, 3'b010);
    conv(64'h3FF8000000000000, 1'b1);
    chk("R9 R10 no exception", {out_we, out_inexact, out_frac_inx}, 3'b111);
    chk("R2 1.5", out_data[63:0], 1);
    conv(64'hBFE0000000000000, 1'b1);
    chk("R3 -0.5 not invalid", {out_we, out_inv_cvt, out_inexact, out_frac_inx}, 4'b1011);
    conv(64'h7FF0000000000000, 1'b1);
    chk("R4 +inf enabled", {out_we, out_inv_cvt, out_data[63:0]}, {2'b01, 64'hFFFFFFFFFFFFFFFF});
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule